// File: doc/BRIEF.md
# Open-Load and Over-Temperature Error Aggregator

This block turns sixteen open-load comparator bits and one over-temperature bit into a single error request and a 17-bit status word. The error request is the enable of an open-drain pull-down: when it is high, the shared error line is driven low. When it is low, the line is released and an external pull-up reads it as high. The analog comparators sit outside the block. Only their digital results enter it.

A comparator bit for a channel counts as an open-load fault only under three conditions: the channel is switched on, the comparator reports a low output voltage, and the channel has been on without a break for a programmable number of clock cycles. This delay, about one microsecond, hides the settling of the output after switch-on. Each channel has its own qualification counter, which restarts whenever that channel goes off.

While the blank input is high, open-load faults do not reach the error line. Over-temperature always reaches it. The qualified open-load flags are copied into the status word when the latch strobe falls. The over-temperature bit appears live in the top status bit.

Top module: `err_flag_agg`

## Requirements
- R1: While `hot_in` is high, `err_pull` is 1 in the next cycle, whatever the value of `blank`.
- R2: While `blank` is high and `hot_in` is low, `err_pull` is 0 in the next cycle, even when qualified open-load faults are present.
- R3: While `hot_in` is low and no channel has a qualified open-load fault, `err_pull` is 0 in the next cycle. With `blank` low and at least one qualified fault, it is 1.
- R4: The open-load fault of channel i is qualified only when `ch_on[i]` and `open_cmp[i]` are both 1 and `ch_on[i]` has been 1 on the previous QUAL_CYC rising edges. An on-pulse that lasts QUAL_CYC cycles or fewer never drives `err_pull`.
- R5: One cycle with `ch_on[i]` low restarts the qualification count of channel i from zero.
- R6: On the first rising edge at which `strobe` is low after being high, `status[i]` (for i in 0..NUM_CH-1) takes the value of channel i's qualified open-load fault. This capture does not depend on `blank`.
- R7: At every other edge, including the edge where `strobe` rises and the edges while it stays high, `status[NUM_CH-1:0]` keeps its value.
- R8: `status[NUM_CH]` equals `hot_in` as registered one cycle earlier. It is never held, so it clears one cycle after `hot_in` clears.
- R9: While `rst_n` is low, `err_pull` and all `status` bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_on | input | NUM_CH | Per-channel output-on enables |
| open_cmp | input | NUM_CH | Per-channel comparator bits; 1 means the output voltage is low |
| hot_in | input | 1 | Over-temperature comparator bit |
| blank | input | 1 | High masks open-load faults at the error output |
| strobe | input | 1 | Latch strobe; its falling edge captures open-load flags |
| err_pull | output | 1 | Pull-down enable for the open-drain error line (1 = drive low) |
| status | output | NUM_CH+1 | Bits NUM_CH-1..0: captured open-load flags; bit NUM_CH: thermal flag |

## Verification
The assertions assume that every input is synchronous to `clk` and stable around its rising edge. They also assume QUAL_CYC is at least one, so that a qualified channel must have been on in the previous cycle. The bench changes all inputs on the falling edge and samples outputs there, one or more full cycles after each change. It uses a short qualification delay so that the boundary between QUAL_CYC and QUAL_CYC+1 on-cycles can be probed directly. The bench holds `hot_in` low during reset, so the first post-reset cycles start from a known thermal state.

// File: rtl/errflag_pkg.sv
package errflag_pkg;
  parameter int unsigned DEF_NUM_CH   = 16;
  parameter int unsigned DEF_QUAL_CYC = 100;

  function automatic int unsigned cnt_bits(input int unsigned limit);
    return (limit < 1) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/open_qual.sv
module open_qual #(
  parameter int unsigned QUAL_CYC = errflag_pkg::DEF_QUAL_CYC
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ch_on,
  input  logic cmp_low,
  output logic fault_o
);
  localparam int unsigned CW = errflag_pkg::cnt_bits(QUAL_CYC);
  localparam logic [CW-1:0] LIMIT = CW'(QUAL_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ready;

  // next-state: count while on, saturate at the limit, restart when off (R5)
  always_comb begin
    if (!ch_on)              cnt_d = '0;
    else if (cnt_q == LIMIT) cnt_d = cnt_q;
    else                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign ready   = ch_on && (cnt_q == LIMIT);
  assign fault_o = ready && cmp_low;

  // R4: a qualified fault implies the channel was already on one cycle ago
  a_r4_on_before_fault: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> $past(ch_on));

  // R5: an off cycle leaves no qualification behind
  a_r5_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_on |=> !fault_o);
endmodule

// File: rtl/lod_capture.sv
module lod_capture #(
  parameter int unsigned NUM_CH = errflag_pkg::DEF_NUM_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [NUM_CH-1:0] flags_i,
  output logic [NUM_CH-1:0] lod_o
);
  logic              strobe_q;
  logic              fall;
  logic [NUM_CH-1:0] lod_q, lod_d;

  assign fall = strobe_q && !strobe;

  always_comb begin
    lod_d = lod_q;
    if (fall) lod_d = flags_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      lod_q    <= '0;
    end else begin
      strobe_q <= strobe;
      lod_q    <= lod_d;
    end
  end

  assign lod_o = lod_q;

  // R7: without a falling strobe the captured flags never move
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> $stable(lod_o));

  // R6: a fall captures exactly the presented flags
  a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_q && !strobe) |=> (lod_o == $past(flags_i)));
endmodule

// File: rtl/err_flag_agg.sv
module err_flag_agg #(
  parameter int unsigned NUM_CH   = errflag_pkg::DEF_NUM_CH,
  parameter int unsigned QUAL_CYC = errflag_pkg::DEF_QUAL_CYC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ch_on,
  input  logic [NUM_CH-1:0] open_cmp,
  input  logic              hot_in,
  input  logic              blank,
  input  logic              strobe,
  output logic              err_pull,
  output logic [NUM_CH:0]   status
);
  localparam int unsigned SW = NUM_CH + 1;

  logic [NUM_CH-1:0] open_flag;
  logic [NUM_CH-1:0] lod_bits;
  logic              err_q, err_d;
  logic              hot_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    open_qual #(.QUAL_CYC(QUAL_CYC)) i_qual (
      .clk     (clk),
      .rst_n   (rst_n),
      .ch_on   (ch_on[g]),
      .cmp_low (open_cmp[g]),
      .fault_o (open_flag[g])
    );
  end

  lod_capture #(.NUM_CH(NUM_CH)) i_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .flags_i (open_flag),
    .lod_o   (lod_bits)
  );

  // next-state of the error pull-down: thermal always, open-load unless blanked
  always_comb begin
    err_d = hot_in || (!blank && (|open_flag));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      hot_q <= 1'b0;
    end else begin
      err_q <= err_d;
      hot_q <= hot_in;
    end
  end

  assign err_pull = err_q;
  assign status   = SW'({hot_q, lod_bits});

  // R1: thermal pulls the line whatever blank does
  a_r1_hot_pulls: assert property (@(posedge clk) disable iff (!rst_n)
    hot_in |=> err_pull);

  // R2: blank hides open-load faults
  a_r2_blank_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (blank && !hot_in) |=> !err_pull);

  // R3: nothing pending means the line is released
  a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!hot_in && (open_flag == '0)) |=> !err_pull);

  // R8: thermal status bit tracks the input with no hold
  a_r8_hot_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !hot_in |=> !status[NUM_CH]);
endmodule

// File: tb/test_err_flag_agg.sv
module test_err_flag_agg;
  localparam int NCH   = 16;
  localparam int QUAL  = 5;
  localparam int TCLK  = 10;

  logic           clk;
  logic           rst_n;
  logic [NCH-1:0] ch_on;
  logic [NCH-1:0] open_cmp;
  logic           hot_in;
  logic           blank;
  logic           strobe;
  logic           err_pull;
  logic [NCH:0]   status;

  int checks;
  int errors;
  bit done;

  err_flag_agg #(.NUM_CH(NCH), .QUAL_CYC(QUAL)) i_err_flag_agg (
    .clk      (clk),
    .rst_n    (rst_n),
    .ch_on    (ch_on),
    .open_cmp (open_cmp),
    .hot_in   (hot_in),
    .blank    (blank),
    .strobe   (strobe),
    .err_pull (err_pull),
    .status   (status)
  );

  initial clk = 1'b0;
  always #(TCLK/2) clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    checks = 0; errors = 0; done = 0;
    rst_n = 0; ch_on = '0; open_cmp = '0; hot_in = 0; blank = 0; strobe = 0;
    step(3);
    // R9: reset state
    chk("R9 err_pull", 32'(err_pull), 0);
    chk("R9 status", 32'(status), 0);
    rst_n = 1;
    step(2);

    // R4: boundary of the qualification window
    ch_on[3] = 1; open_cmp[3] = 1;
    step(QUAL);
    chk("R4 not yet qualified", 32'(err_pull), 0);
    step(1);
    chk("R4 qualified", 32'(err_pull), 1);
    ch_on = '0; open_cmp = '0;
    step(2);
    chk("R3 released after off", 32'(err_pull), 0);

    // R4: pulse of exactly QUAL cycles never flags
    ch_on[7] = 1; open_cmp[7] = 1;
    for (int k = 0; k < QUAL; k++) begin
      step(1);
      chk("R4 short pulse", 32'(err_pull), 0);
    end
    ch_on[7] = 0;
    for (int k = 0; k < 3; k++) begin
      step(1);
      chk("R4 short pulse tail", 32'(err_pull), 0);
    end
    open_cmp = '0;

    // R5: one off cycle restarts the count
    ch_on[2] = 1; open_cmp[2] = 1;
    step(QUAL - 1);
    ch_on[2] = 0;
    step(1);
    ch_on[2] = 1;
    step(QUAL);
    chk("R5 restart not qualified", 32'(err_pull), 0);
    step(1);
    chk("R5 restart qualified", 32'(err_pull), 1);
    ch_on = '0; open_cmp = '0;
    step(2);

    // R1/R2/R3/R8: truth-table sweep with all channels qualified
    ch_on = '1;
    step(QUAL + 1);
    for (int c = 0; c < 8; c++) begin
      logic h, o, b;
      h = c[2]; o = c[1]; b = c[0];
      hot_in = h; blank = b;
      open_cmp = o ? 16'hA5C3 : 16'h0000;
      step(1);
      chk(h ? "R1 sweep" : (b ? "R2 sweep" : "R3 sweep"),
          32'(err_pull), 32'(h | (o & ~b)));
      chk("R8 sweep", 32'(status[NCH]), 32'(h));
    end
    hot_in = 0;

    // R6/R7: capture on strobe fall, with blank high
    blank = 1; open_cmp = 16'h5A0F;
    step(1);
    strobe = 1;
    step(1);
    chk("R7 hold at rise", 32'(status[NCH-1:0]), 0);
    step(2);
    chk("R7 hold while high", 32'(status[NCH-1:0]), 0);
    strobe = 0;
    step(1);
    chk("R6 capture", 32'(status[NCH-1:0]), 32'h5A0F);
    open_cmp = 16'h00F0;
    step(3);
    chk("R7 hold while low", 32'(status[NCH-1:0]), 32'h5A0F);

    // R6/R4: only qualified channels are captured
    ch_on = 16'h00FF;
    step(1);
    ch_on = 16'h80FF; open_cmp = 16'h80F0;
    strobe = 1;
    step(1);
    strobe = 0;
    step(1);
    chk("R6 partial capture", 32'(status[NCH-1:0]), 32'h00F0);

    // R1/R8: thermal clears with no hold
    blank = 1; ch_on = '0; open_cmp = '0;
    hot_in = 1;
    step(1);
    chk("R1 hot with blank", 32'(err_pull), 1);
    chk("R8 hot set", 32'(status[NCH]), 1);
    hot_in = 0;
    step(1);
    chk("R8 hot cleared", 32'(status[NCH]), 0);
    chk("R3 release after hot", 32'(err_pull), 0);

    done = 1;
    finish_run();
  end
endmodule